// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-based processor. It is purely combinational: given an accumulator operand, a second operand, a carry input, the current status byte and a 4-bit operation code, it returns the operation result, a strobe that says whether the result should be written back, and the updated status byte. The status byte holds six flags: carry, zero, sign, half-carry, subtract indicator, and one shared bit that reports either signed overflow or even parity, depending on the class of operation.

Flags that an operation does not touch are copied from the incoming status byte, so the caller can feed the previous status straight back in. Double-width additions are built from two passes of the wide-add code, first with carry input 0 on the low bytes and then with the first pass's carry on the high bytes. Only carry and half-carry change in this mode. After the high pass, half-carry therefore holds the carry out of bit 11 of the 16-bit sum.

Top module: `alu8_status`

## Requirements
- R1: Operation codes on `opSel`: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 negate, 11 complement, 12 set carry, 13 complement carry, 14 wide add, 15 no operation. The operand of increment, decrement, negate and complement is `opA`.
- R2: The status byte is laid out as sign (bit 7), zero (bit 6), half-carry (bit 4), shared parity/overflow (bit 2), subtract (bit 1) and carry (bit 0). Bits 5 and 3 of `flagsOut` are always 0.
- R3: Add returns opA+opB and add with carry returns opA+opB+carryIn, modulo 256. Carry is the carry out of bit 7, and the subtract flag is cleared.
- R4: Subtract returns opA-opB and subtract with borrow returns opA-opB-carryIn, modulo 256. Carry is set on a borrow, and the subtract flag is set.
- R5: Compare produces exactly the flags of subtract, with `resultWe` low.
- R6: For add, add with carry, subtract, subtract with borrow, compare, increment, decrement and negate, the shared flag is 1 exactly when the signed result falls outside -128..127.
- R7: Half-carry is the carry out of bit 3 for additions (including increment and wide add). It is the borrow into bit 4 for subtractions (including decrement and negate).
- R8: AND, OR and XOR return the bitwise result, clear carry and subtract, and set the shared flag to 1 when the result has an even number of one bits. AND sets half-carry; OR and XOR clear it.
- R9: Every operation except complement, set carry, complement carry, wide add and no operation sets zero to (result == 0) and sign to result bit 7.
- R10: Increment and decrement return opA±1 and leave carry equal to flagsIn bit 0. Increment clears the subtract flag; decrement sets it.
- R11: Negate returns 0-opA. Carry is 1 unless opA is 0, the shared flag is 1 only for opA = 0x80, and the subtract flag is set.
- R12: Complement returns ~opA with write enabled. It sets half-carry and subtract and keeps all other flags.
- R13: Set carry forces carry to 1 and clears half-carry and subtract. Complement carry inverts flagsIn carry, clears subtract and keeps half-carry. Neither writes a result, and neither changes sign, zero or the shared flag.
- R14: Wide add returns opA+opB+carryIn with write enabled. It updates carry and half-carry, clears subtract, and keeps sign, zero and the shared flag. No operation writes nothing and keeps all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Accumulator operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry/borrow input for the carry-using operations |
| opSel | input | 4 | Operation code (see R1) |
| flagsIn | input | 8 | Current status byte |
| result | output | 8 | Operation result |
| resultWe | output | 1 | High when the result is to be written back |
| flagsOut | output | 8 | Updated status byte |

## Verification
The checks assume that `opSel` is always one of the sixteen defined codes. Because the block has no state, they compare outputs with inputs in the same settled evaluation. `flagsIn` may hold any value, including ones in the reserved bits 5 and 3, and the checks on flag pass-through and on the reserved bits depend on that. The stimulus therefore sets `flagsIn` to all-ones, all-zeros and mixed patterns. It drives inputs only between clock edges, so every output is sampled after it has settled.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC  = 4'd3,
    OP_CP   = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_NEG  = 4'd10, OP_CPL  = 4'd11,
    OP_SCF  = 4'd12, OP_CCF  = 4'd13, OP_ADDW = 4'd14, OP_NOP  = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {Y_B, Y_ONE, Y_A} ySel_e;
  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_PORT, CI_PORTN} cinSel_e;
  typedef enum logic [2:0] {RES_SUM, RES_AND, RES_OR, RES_XOR, RES_NOT, RES_PASS} resSel_e;
  typedef enum logic [2:0] {C_KEEP, C_ARITH, C_ZERO, C_ONE, C_INV} cMode_e;
  typedef enum logic [1:0] {H_KEEP, H_ARITH, H_ZERO, H_ONE} hMode_e;
  typedef enum logic [1:0] {PV_KEEP, PV_OVF, PV_PAR} pvMode_e;
  typedef enum logic [1:0] {N_KEEP, N_ZERO, N_ONE} nMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    xZero;
    ySel_e   ySel;
    logic    invY;
    cinSel_e cinSel;
    resSel_e resSel;
    logic    writeEn;
    cMode_e  cMode;
    hMode_e  hMode;
    pvMode_e pvMode;
    logic    szUpd;
    nMode_e  nMode;
  } aluCtrl_t;

  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  aluOp_e   op,
  output aluCtrl_t ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.ySel   = Y_B;
    ctrl.cinSel = CI_ZERO;
    ctrl.resSel = RES_PASS;
    ctrl.cMode  = C_KEEP;
    ctrl.hMode  = H_KEEP;
    ctrl.pvMode = PV_KEEP;
    ctrl.nMode  = N_KEEP;
    unique case (op)
      OP_ADD, OP_ADC: begin
        ctrl.cinSel  = (op == OP_ADC) ? CI_PORT : CI_ZERO;
        ctrl.resSel  = RES_SUM;
        ctrl.writeEn = 1'b1;
        ctrl.cMode   = C_ARITH;
        ctrl.hMode   = H_ARITH;
        ctrl.pvMode  = PV_OVF;
        ctrl.szUpd   = 1'b1;
        ctrl.nMode   = N_ZERO;
      end
      OP_SUB, OP_SBC, OP_CP: begin
        ctrl.invY    = 1'b1;
        ctrl.cinSel  = (op == OP_SBC) ? CI_PORTN : CI_ONE;
        ctrl.resSel  = RES_SUM;
        ctrl.writeEn = (op != OP_CP);
        ctrl.cMode   = C_ARITH;
        ctrl.hMode   = H_ARITH;
        ctrl.pvMode  = PV_OVF;
        ctrl.szUpd   = 1'b1;
        ctrl.nMode   = N_ONE;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.resSel  = (op == OP_AND) ? RES_AND : (op == OP_OR) ? RES_OR : RES_XOR;
        ctrl.writeEn = 1'b1;
        ctrl.cMode   = C_ZERO;
        ctrl.hMode   = (op == OP_AND) ? H_ONE : H_ZERO;
        ctrl.pvMode  = PV_PAR;
        ctrl.szUpd   = 1'b1;
        ctrl.nMode   = N_ZERO;
      end
      OP_INC, OP_DEC: begin
        ctrl.ySel    = Y_ONE;
        ctrl.invY    = (op == OP_DEC);
        ctrl.cinSel  = (op == OP_DEC) ? CI_ONE : CI_ZERO;
        ctrl.resSel  = RES_SUM;
        ctrl.writeEn = 1'b1;
        ctrl.hMode   = H_ARITH;
        ctrl.pvMode  = PV_OVF;
        ctrl.szUpd   = 1'b1;
        ctrl.nMode   = (op == OP_DEC) ? N_ONE : N_ZERO;
      end
      OP_NEG: begin
        ctrl.xZero   = 1'b1;
        ctrl.ySel    = Y_A;
        ctrl.invY    = 1'b1;
        ctrl.cinSel  = CI_ONE;
        ctrl.resSel  = RES_SUM;
        ctrl.writeEn = 1'b1;
        ctrl.cMode   = C_ARITH;
        ctrl.hMode   = H_ARITH;
        ctrl.pvMode  = PV_OVF;
        ctrl.szUpd   = 1'b1;
        ctrl.nMode   = N_ONE;
      end
      OP_CPL: begin
        ctrl.resSel  = RES_NOT;
        ctrl.writeEn = 1'b1;
        ctrl.hMode   = H_ONE;
        ctrl.nMode   = N_ONE;
      end
      OP_SCF: begin
        ctrl.cMode = C_ONE;
        ctrl.hMode = H_ZERO;
        ctrl.nMode = N_ZERO;
      end
      OP_CCF: begin
        ctrl.cMode = C_INV;
        ctrl.nMode = N_ZERO;
      end
      OP_ADDW: begin
        ctrl.cinSel  = CI_PORT;
        ctrl.resSel  = RES_SUM;
        ctrl.writeEn = 1'b1;
        ctrl.cMode   = C_ARITH;
        ctrl.hMode   = H_ARITH;
        ctrl.nMode   = N_ZERO;
      end
      default: ; // no operation: defaults keep everything
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [7:0]       flagsIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic [7:0]       flagsOut
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] xOp, yRaw, yOp;
  logic             cinEff;
  logic [WIDTH:0]   sumFull;
  logic [HALF:0]    nibSum;
  logic             carryOut, halfOut, overflow, parityEven;

  always_comb begin
    xOp = ctrl.xZero ? '0 : opA;
    unique case (ctrl.ySel)
      Y_ONE:   yRaw = WIDTH'(1);
      Y_A:     yRaw = opA;
      default: yRaw = opB;
    endcase
    yOp = ctrl.invY ? ~yRaw : yRaw;
    unique case (ctrl.cinSel)
      CI_ONE:   cinEff = 1'b1;
      CI_PORT:  cinEff = carryIn;
      CI_PORTN: cinEff = ~carryIn;
      default:  cinEff = 1'b0;
    endcase
  end

  assign sumFull  = {1'b0, xOp} + {1'b0, yOp} + {{WIDTH{1'b0}}, cinEff};
  assign nibSum   = {1'b0, xOp[HALF-1:0]} + {1'b0, yOp[HALF-1:0]} + {{HALF{1'b0}}, cinEff};
  // subtraction reports borrow, i.e. the inverted carry
  assign carryOut = sumFull[WIDTH] ^ ctrl.invY;
  assign halfOut  = nibSum[HALF] ^ ctrl.invY;
  assign overflow = (xOp[WIDTH-1] == yOp[WIDTH-1]) && (sumFull[WIDTH-1] != xOp[WIDTH-1]);

  always_comb begin
    unique case (ctrl.resSel)
      RES_SUM: result = sumFull[WIDTH-1:0];
      RES_AND: result = opA & opB;
      RES_OR:  result = opA | opB;
      RES_XOR: result = opA ^ opB;
      RES_NOT: result = ~opA;
      default: result = opA;
    endcase
  end

  assign parityEven = ~^result;
  assign resultWe   = ctrl.writeEn;

  always_comb begin
    flagsOut = flagsIn & 8'b1101_0111;
    if (ctrl.szUpd) begin
      flagsOut[FLG_S] = result[WIDTH-1];
      flagsOut[FLG_Z] = (result == '0);
    end
    unique case (ctrl.cMode)
      C_ARITH: flagsOut[FLG_C] = carryOut;
      C_ZERO:  flagsOut[FLG_C] = 1'b0;
      C_ONE:   flagsOut[FLG_C] = 1'b1;
      C_INV:   flagsOut[FLG_C] = ~flagsIn[FLG_C];
      default: ;
    endcase
    unique case (ctrl.hMode)
      H_ARITH: flagsOut[FLG_H] = halfOut;
      H_ZERO:  flagsOut[FLG_H] = 1'b0;
      H_ONE:   flagsOut[FLG_H] = 1'b1;
      default: ;
    endcase
    unique case (ctrl.pvMode)
      PV_OVF:  flagsOut[FLG_PV] = overflow;
      PV_PAR:  flagsOut[FLG_PV] = parityEven;
      default: ;
    endcase
    unique case (ctrl.nMode)
      N_ZERO:  flagsOut[FLG_N] = 1'b0;
      N_ONE:   flagsOut[FLG_N] = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [3:0]       opSel,
  input  logic [7:0]       flagsIn,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic [7:0]       flagsOut
);

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .op   (aluOp_e'(opSel)),
    .ctrl (ctrl)
  );

  alu8_dp #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .flagsIn  (flagsIn),
    .ctrl     (ctrl),
    .result   (result),
    .resultWe (resultWe),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [3:0]       opSel,
  input logic [7:0]       flagsIn,
  input logic [WIDTH-1:0] result,
  input logic             resultWe,
  input logic [7:0]       flagsOut
);

  always_comb begin
    // R2: reserved bits of the status byte
    a_r2_reserved_zero: assert (flagsOut[5] == 1'b0 && flagsOut[3] == 1'b0)
      else $error("reserved status bits not zero");

    // R5: compare never writes
    if (opSel == 4'd4)
      a_r5_compare_no_write: assert (!resultWe && flagsOut[1])
        else $error("compare wrote result or cleared subtract");

    // R8: logic operations clear carry and subtract
    if (opSel >= 4'd5 && opSel <= 4'd7)
      a_r8_logic_clears_carry: assert (!flagsOut[0] && !flagsOut[1] && flagsOut[2] == ~^result)
        else $error("logic op carry/subtract/parity wrong");

    // R9: zero and sign follow the result
    if (opSel <= 4'd10)
      a_r9_zero_sign: assert (flagsOut[6] == (result == '0) && flagsOut[7] == result[WIDTH-1])
        else $error("zero/sign flag mismatch");

    // R10: increment/decrement keep carry
    if (opSel == 4'd8 || opSel == 4'd9)
      a_r10_carry_kept: assert (flagsOut[0] == flagsIn[0])
        else $error("inc/dec changed carry");

    // R12: complement
    if (opSel == 4'd11)
      a_r12_complement: assert (result == ~opA && resultWe && flagsOut[4] && flagsOut[1])
        else $error("complement wrong");

    // R14: no operation keeps every flag and does not write
    if (opSel == 4'd15)
      a_r14_nop_keeps: assert (!resultWe && flagsOut == (flagsIn & 8'hD7))
        else $error("no-op changed state");

    // R14: wide add keeps sign, zero and the shared flag
    if (opSel == 4'd14)
      a_r14_wide_keeps: assert (flagsOut[7] == flagsIn[7] && flagsOut[6] == flagsIn[6]
                                && flagsOut[2] == flagsIn[2] && !flagsOut[1])
        else $error("wide add touched kept flags");
  end

  // opB is only observed through the result
  logic unusedB;
  assign unusedB = ^{opB, carryIn};

endmodule

bind alu8_status alu8_status_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_status_test.sv
module alu8_status_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0, opB = '0, flagsIn = '0;
  logic       carryIn = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] result, flagsOut;
  logic       resultWe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_status uut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .flagsIn(flagsIn), .result(result), .resultWe(resultWe), .flagsOut(flagsOut)
  );

  // Expected {we, result, flags} derived from the requirements
  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                        input logic ci, input logic [7:0] fin);
    int r, sr, ciI;
    logic [7:0] res;
    logic we, s, z, h, pv, n, c;
    s = fin[7]; z = fin[6]; h = fin[4]; pv = fin[2]; n = fin[1]; c = fin[0];
    res = a; we = 1'b0;
    ciI = int'(ci);
    case (op)
      4'd0, 4'd1, 4'd14: begin
        if (op == 4'd0) ciI = 0;
        r = int'(a) + int'(b) + ciI;
        res = 8'(r); we = 1'b1;
        c = (r > 255);
        h = ((int'(a) % 16) + (int'(b) % 16) + ciI) > 15;
        n = 1'b0;
        if (op != 4'd14) begin
          sr = int'($signed(a)) + int'($signed(b)) + ciI;
          pv = (sr > 127) || (sr < -128);
          s = res[7]; z = (res == 8'h00);
        end
      end
      4'd2, 4'd3, 4'd4: begin
        if (op != 4'd3) ciI = 0;
        r = int'(a) - int'(b) - ciI;
        res = 8'(r); we = (op != 4'd4);
        c = (r < 0);
        h = ((int'(a) % 16) - (int'(b) % 16) - ciI) < 0;
        sr = int'($signed(a)) - int'($signed(b)) - ciI;
        pv = (sr > 127) || (sr < -128);
        n = 1'b1; s = res[7]; z = (res == 8'h00);
      end
      4'd5, 4'd6, 4'd7: begin
        res = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) : (a ^ b);
        we = 1'b1; c = 1'b0; h = (op == 4'd5); n = 1'b0;
        pv = ($countones(res) % 2) == 0;
        s = res[7]; z = (res == 8'h00);
      end
      4'd8: begin
        res = a + 8'd1; we = 1'b1;
        h = (a[3:0] == 4'hF); pv = (a == 8'h7F); n = 1'b0;
        s = res[7]; z = (res == 8'h00);
      end
      4'd9: begin
        res = a - 8'd1; we = 1'b1;
        h = (a[3:0] == 4'h0); pv = (a == 8'h80); n = 1'b1;
        s = res[7]; z = (res == 8'h00);
      end
      4'd10: begin
        res = 8'h00 - a; we = 1'b1;
        c = (a != 8'h00); h = (a[3:0] != 4'h0); pv = (a == 8'h80); n = 1'b1;
        s = res[7]; z = (res == 8'h00);
      end
      4'd11: begin res = ~a; we = 1'b1; h = 1'b1; n = 1'b1; end
      4'd12: begin c = 1'b1; h = 1'b0; n = 1'b0; end
      4'd13: begin c = ~c; n = 1'b0; end
      default: ;
    endcase
    return {we, res, s, z, 1'b0, h, 1'b0, pv, n, c};
  endfunction

  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic [7:0] fin);
    logic [16:0] exp, act;
    @(negedge clk);
    opSel = op; opA = a; opB = b; carryIn = ci; flagsIn = fin;
    #2;
    exp = model(op, a, b, ci, fin);
    act = {resultWe, result, flagsOut};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%b fin=%h: actual we=%b res=%h flags=%h expected we=%b res=%h flags=%h",
               tag, op, a, b, ci, fin, act[16], act[15:8], act[7:0], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic expectBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic t_idle;  // R1 code 0 after reset, R2 layout
    apply("R1", 4'd0, 8'h00, 8'h00, 1'b0, 8'h00);
    expectBit("R2 zero at bit 6", flagsOut[6], 1'b1);
    apply("R2", 4'd15, 8'h12, 8'h34, 1'b1, 8'hFF);
    expectBit("R2 reserved bit 5", flagsOut[5], 1'b0);
  endtask

  task automatic t_add;
    apply("R3", 4'd0, 8'h12, 8'h34, 1'b1, 8'hFF);
    apply("R3", 4'd0, 8'hF0, 8'h10, 1'b0, 8'h00);
    apply("R3", 4'd1, 8'hFF, 8'h00, 1'b1, 8'h00);
    expectBit("R3 carry out", flagsOut[0], 1'b1);
    apply("R6", 4'd0, 8'h7F, 8'h01, 1'b0, 8'h00);
    expectBit("R6 add overflow", flagsOut[2], 1'b1);
    apply("R7", 4'd0, 8'h0F, 8'h01, 1'b0, 8'h00);
    expectBit("R7 add half-carry", flagsOut[4], 1'b1);
  endtask

  task automatic t_sub;
    apply("R4", 4'd2, 8'h10, 8'h01, 1'b1, 8'h00);
    expectBit("R7 sub half-borrow", flagsOut[4], 1'b1);
    apply("R4", 4'd2, 8'h00, 8'h01, 1'b0, 8'hFF);
    expectBit("R4 borrow", flagsOut[0], 1'b1);
    apply("R4", 4'd3, 8'h50, 8'h50, 1'b1, 8'h00);
    apply("R6", 4'd2, 8'h80, 8'h01, 1'b0, 8'h00);
    expectBit("R6 sub overflow", flagsOut[2], 1'b1);
  endtask

  task automatic t_cp;
    apply("R5", 4'd4, 8'h42, 8'h42, 1'b0, 8'h00);
    expectBit("R5 no write", resultWe, 1'b0);
    apply("R5", 4'd4, 8'h10, 8'h20, 1'b1, 8'hFF);
  endtask

  task automatic t_logic;
    apply("R8", 4'd5, 8'hF0, 8'h3C, 1'b1, 8'hFF);
    apply("R8", 4'd6, 8'h01, 8'h02, 1'b0, 8'h00);
    apply("R8", 4'd7, 8'hAA, 8'hAA, 1'b1, 8'hFF);
    expectBit("R9 zero from xor", flagsOut[6], 1'b1);
    apply("R8", 4'd7, 8'h01, 8'h80, 1'b0, 8'h00);
    expectBit("R9 sign", flagsOut[7], 1'b1);
  endtask

  task automatic t_incdec;
    apply("R10", 4'd8, 8'h7F, 8'h00, 1'b0, 8'h01);
    apply("R10", 4'd8, 8'hFF, 8'h00, 1'b1, 8'h00);
    expectBit("R10 carry kept on wrap", flagsOut[0], 1'b0);
    apply("R10", 4'd9, 8'h80, 8'h00, 1'b0, 8'h01);
    apply("R10", 4'd9, 8'h01, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic t_neg;
    apply("R11", 4'd10, 8'h00, 8'h55, 1'b1, 8'hFF);
    apply("R11", 4'd10, 8'h80, 8'h00, 1'b0, 8'h00);
    apply("R11", 4'd10, 8'h01, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic t_cpl;
    apply("R12", 4'd11, 8'h5A, 8'h00, 1'b0, 8'h00);
    apply("R12", 4'd11, 8'hFF, 8'h00, 1'b1, 8'hC5);
  endtask

  task automatic t_carryOps;
    apply("R13", 4'd12, 8'h11, 8'h22, 1'b0, 8'h12);
    apply("R13", 4'd13, 8'h11, 8'h22, 1'b0, 8'hD7);
    apply("R13", 4'd13, 8'h11, 8'h22, 1'b1, 8'h10);
  endtask

  task automatic t_wide;  // R14: 0x0FFF + 0x0001 across two passes
    logic cLow;
    apply("R14", 4'd14, 8'hFF, 8'h01, 1'b0, 8'hC4);
    cLow = flagsOut[0];
    expectBit("R14 low carry", cLow, 1'b1);
    apply("R14", 4'd14, 8'h0F, 8'h00, cLow, flagsOut);
    expectBit("R14 bit-11 half-carry", flagsOut[4], 1'b1);
    apply("R14", 4'd15, 8'h33, 8'h44, 1'b1, 8'h97);
  endtask

  task automatic t_sweep;  // R1 all codes over a grid
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 12; i++)
        apply("R1", 4'(op), 8'(i * 23 + 5), 8'(i * 41 + 128), i[0], 8'(i * 37));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_cp();
    t_logic();
    t_incdec();
    t_neg();
    t_cpl();
    t_carryOps();
    t_wide();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule